// File: doc/BRIEF.md
# Asynchronous SRAM Access Controller

This block sits between a clocked host and an external asynchronous static RAM of 32,768 bytes. It has a 15-bit address and an 8-bit data path. The host makes one single-beat request at a time through a valid/ready handshake, with a flag that selects a write or a read. The controller registers the address and the write data, then drives the RAM's active-low select, write and output strobes. It holds each strobe for a whole number of clock cycles, computed from nanosecond timing parameters and the clock period. A read returns its byte to the host with a one-cycle valid pulse.

The RAM data pins form a shared tri-state bus. The controller splits that bus into a registered output value, a driver enable and an input path. The output strobe stays inactive for the whole of a write. The controller turns its own driver on only when two conditions are met: the RAM has been given its worst-case float time after the last read, and the write strobe is falling. When no access is in progress, the select strobe stays inactive so the RAM sits in standby.

Top module: `sramc_ctrl`

## Requirements
- R1: While reset is held and on the first cycle after it, the select, write and output strobes are high, the driver enable is low, the response valid is low and the request ready is high.
- R2: Whenever the controller is ready for a request, the select strobe is high (standby).
- R3: During a write the select and write strobes are low together, and the output strobe is high in every cycle in which the write strobe is low.
- R4: The write strobe stays low for exactly max(ceil(tWP/T), ceil(tDS/T), ceil(tWC/T)-1) cycles, where T is the clock period and each term is at least 1. At the default timing and 4 ns clock this is 2 cycles.
- R5: The address does not change while the select strobe stays low. The write strobe falls only after the select strobe and the address have already been applied for at least one cycle.
- R6: The data driver is enabled only while the write strobe is low. While enabled it carries the write data that was accepted with the request.
- R7: A read holds the select and output strobes low, with the write strobe high, for exactly ceil(max(tRC, tAA, tAOE)/T) cycles (3 at the defaults). It samples the data bus at the end of the last of those cycles.
- R8: Each read returns its byte with a response valid that lasts exactly one cycle. Request ready stays low from acceptance through that cycle.
- R9: After the output strobe rises, the data driver stays disabled for at least ceil(tHZOE/T) cycles.
- R10: For each write, the select strobe stays low for at least ceil(tWC/T) cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Host request present |
| req_ready | output | 1 | Controller can accept a request |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 15 | Byte address |
| req_wdata | input | 8 | Write data |
| rsp_rdata | output | 8 | Read data |
| rsp_valid | output | 1 | One-cycle pulse when rsp_rdata holds a read result |
| mem_addr | output | 15 | RAM address |
| mem_ce_n | output | 1 | RAM select, active low |
| mem_we_n | output | 1 | RAM write strobe, active low |
| mem_oe_n | output | 1 | RAM output strobe, active low |
| mem_dq_out | output | 8 | Value for the data bus driver |
| mem_dq_oe | output | 1 | Data bus driver enable, active high |
| mem_dq_in | input | 8 | Value seen on the data bus |

## Verification
The bench's RAM model returns a poison byte (0xA5) until the strobes have been held for the full read time. A controller that samples one cycle early therefore hands back the wrong byte. The bench builds the output-float time up to five cycles and issues writes right after reads. A controller that drives the bus too soon after the output strobe rises is caught by the turnaround measurement. The bench measures the length of every write pulse and every read window. It also watches for address changes under an active select and for any cycle with the output and write strobes low together. A shortened strobe, a drifting address or a write that turns the RAM's outputs on all show up as a failed width, a corrupted read-back or a strobe conflict.

// File: rtl/sramc_pkg.sv
package sramc_pkg;

    localparam int unsigned SRAMC_ADDR_W = 15;
    localparam int unsigned SRAMC_DATA_W = 8;

    // Whole clock cycles covering a nanosecond interval, never fewer than one.
    function automatic int unsigned ns_to_cycles(input int unsigned t_ns,
                                                 input int unsigned period_ns);
        int unsigned c;
        c = (t_ns + period_ns - 1) / period_ns;
        return (c == 0) ? 1 : c;
    endfunction

    function automatic int unsigned max3(input int unsigned a,
                                         input int unsigned b,
                                         input int unsigned c);
        int unsigned m;
        m = (a > b) ? a : b;
        return (m > c) ? m : c;
    endfunction

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_READ,
        ST_RESP,
        ST_WGAP,
        ST_WPULSE
    } sramc_state_e;

    // Registered memory-side control strobes.
    typedef struct packed {
        logic ce_n;
        logic we_n;
        logic oe_n;
        logic drv;
    } sramc_strobe_t;

    localparam sramc_strobe_t STROBE_IDLE = '{ce_n: 1'b1, we_n: 1'b1, oe_n: 1'b1, drv: 1'b0};

endpackage

// File: rtl/sramc_timer.sv
module sramc_timer #(
    parameter int unsigned CW = 4
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          load,
    input  logic [CW-1:0] load_val,
    output logic          expired
);
    logic [CW-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q <= '0;
        end else if (load) begin
            cnt_q <= load_val;
        end else if (cnt_q != '0) begin
            cnt_q <= cnt_q - 1'b1;
        end
    end

    assign expired = (cnt_q == '0);
endmodule

// File: rtl/sramc_turnaround.sv
module sramc_turnaround #(
    parameter int unsigned HOLD_CYC = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic start,
    output logic bus_free
);
    localparam int unsigned CW = (HOLD_CYC > 1) ? $clog2(HOLD_CYC) : 1;
    localparam logic [CW-1:0] RELOAD = CW'(HOLD_CYC - 1);

    logic [CW-1:0] cnt_q;

    // Loaded on the edge that raises the output strobe. The driver may turn on
    // once HOLD_CYC edges have passed since that edge.
    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q <= '0;
        end else if (start) begin
            cnt_q <= RELOAD;
        end else if (cnt_q != '0) begin
            cnt_q <= cnt_q - 1'b1;
        end
    end

    assign bus_free = (cnt_q == '0);
endmodule

// File: rtl/sramc_ctrl.sv
module sramc_ctrl
    import sramc_pkg::*;
#(
    parameter int unsigned ADDR_W        = SRAMC_ADDR_W,
    parameter int unsigned DATA_W        = SRAMC_DATA_W,
    parameter int unsigned CLK_PERIOD_NS = 4,
    parameter int unsigned T_RC_NS       = 10,
    parameter int unsigned T_AA_NS       = 10,
    parameter int unsigned T_AOE_NS      = 5,
    parameter int unsigned T_WC_NS       = 10,
    parameter int unsigned T_WP_NS       = 8,
    parameter int unsigned T_DS_NS       = 7,
    parameter int unsigned T_HZOE_NS     = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic              req_write,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [DATA_W-1:0] req_wdata,
    output logic [DATA_W-1:0] rsp_rdata,
    output logic              rsp_valid,
    output logic [ADDR_W-1:0] mem_addr,
    output logic              mem_ce_n,
    output logic              mem_we_n,
    output logic              mem_oe_n,
    output logic [DATA_W-1:0] mem_dq_out,
    output logic              mem_dq_oe,
    input  logic [DATA_W-1:0] mem_dq_in
);
    localparam int unsigned RD_CYC = max3(ns_to_cycles(T_RC_NS, CLK_PERIOD_NS),
                                          ns_to_cycles(T_AA_NS, CLK_PERIOD_NS),
                                          ns_to_cycles(T_AOE_NS, CLK_PERIOD_NS));
    localparam int unsigned WC_CYC = ns_to_cycles(T_WC_NS, CLK_PERIOD_NS);
    // The select strobe is already low for one cycle before the write strobe falls.
    localparam int unsigned WP_CYC = max3(ns_to_cycles(T_WP_NS, CLK_PERIOD_NS),
                                          ns_to_cycles(T_DS_NS, CLK_PERIOD_NS),
                                          (WC_CYC > 1) ? WC_CYC - 1 : 1);
    localparam int unsigned HZ_CYC = ns_to_cycles(T_HZOE_NS, CLK_PERIOD_NS);
    localparam int unsigned TMAX   = (RD_CYC > WP_CYC) ? RD_CYC : WP_CYC;
    localparam int unsigned TCW    = (TMAX > 1) ? $clog2(TMAX) : 1;
    localparam logic [TCW-1:0] RD_LOAD = TCW'(RD_CYC - 1);
    localparam logic [TCW-1:0] WP_LOAD = TCW'(WP_CYC - 1);

    sramc_state_e      state_q;
    sramc_strobe_t     strb_q;
    logic [DATA_W-1:0] wdata_q;
    logic [DATA_W-1:0] rdata_q;
    logic              rsp_q;

    logic              tmr_load;
    logic [TCW-1:0]    tmr_val;
    logic              tmr_done;
    logic              rd_finish;
    logic              bus_free;

    assign rd_finish = (state_q == ST_READ) && tmr_done;
    assign tmr_load  = ((state_q == ST_IDLE) && req_valid && !req_write) ||
                       ((state_q == ST_WGAP) && bus_free);
    assign tmr_val   = (state_q == ST_IDLE) ? RD_LOAD : WP_LOAD;

    sramc_timer #(.CW(TCW)) u_timer (
        .clk      (clk),
        .rst      (rst),
        .load     (tmr_load),
        .load_val (tmr_val),
        .expired  (tmr_done)
    );

    sramc_turnaround #(.HOLD_CYC(HZ_CYC)) u_turn (
        .clk      (clk),
        .rst      (rst),
        .start    (rd_finish),
        .bus_free (bus_free)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q  <= ST_IDLE;
            strb_q   <= STROBE_IDLE;
            mem_addr <= '0;
            wdata_q  <= '0;
            rdata_q  <= '0;
            rsp_q    <= 1'b0;
        end else begin
            rsp_q <= 1'b0;
            unique case (state_q)
                ST_IDLE: begin
                    if (req_valid) begin
                        mem_addr    <= req_addr;
                        wdata_q     <= req_wdata;
                        strb_q.ce_n <= 1'b0;
                        if (req_write) begin
                            state_q <= ST_WGAP;
                        end else begin
                            strb_q.oe_n <= 1'b0;
                            state_q     <= ST_READ;
                        end
                    end
                end
                ST_READ: begin
                    if (tmr_done) begin
                        rdata_q     <= mem_dq_in;
                        strb_q.oe_n <= 1'b1;
                        strb_q.ce_n <= 1'b1;
                        rsp_q       <= 1'b1;
                        state_q     <= ST_RESP;
                    end
                end
                ST_RESP: begin
                    state_q <= ST_IDLE;
                end
                ST_WGAP: begin
                    if (bus_free) begin
                        strb_q.we_n <= 1'b0;
                        strb_q.drv  <= 1'b1;
                        state_q     <= ST_WPULSE;
                    end
                end
                ST_WPULSE: begin
                    if (tmr_done) begin
                        strb_q.we_n <= 1'b1;
                        strb_q.drv  <= 1'b0;
                        strb_q.ce_n <= 1'b1;
                        state_q     <= ST_IDLE;
                    end
                end
                default: begin
                    state_q <= ST_IDLE;
                    strb_q  <= STROBE_IDLE;
                end
            endcase
        end
    end

    assign req_ready  = (state_q == ST_IDLE);
    assign rsp_rdata  = rdata_q;
    assign rsp_valid  = rsp_q;
    assign mem_ce_n   = strb_q.ce_n;
    assign mem_we_n   = strb_q.we_n;
    assign mem_oe_n   = strb_q.oe_n;
    assign mem_dq_oe  = strb_q.drv;
    assign mem_dq_out = wdata_q;
endmodule

// File: rtl/sramc_ctrl_chk.sv
module sramc_ctrl_chk #(
    parameter int unsigned ADDR_W = 15,
    parameter int unsigned HZ_CYC = 2,
    parameter int unsigned WP_CYC = 2
) (
    input logic              clk,
    input logic              rst,
    input logic              req_ready,
    input logic              rsp_valid,
    input logic [ADDR_W-1:0] mem_addr,
    input logic              mem_ce_n,
    input logic              mem_we_n,
    input logic              mem_oe_n,
    input logic              mem_dq_oe
);
    logic [31:0] oe_gap_q;
    logic [31:0] we_low_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            oe_gap_q <= '1;
            we_low_q <= '0;
        end else begin
            if (!mem_oe_n)             oe_gap_q <= '0;
            else if (oe_gap_q != '1)   oe_gap_q <= oe_gap_q + 1'b1;
            if (mem_we_n)              we_low_q <= '0;
            else if (we_low_q != '1)   we_low_q <= we_low_q + 1'b1;
        end
    end

    p_idle_standby_r2: assert property (@(posedge clk) disable iff (rst)
        req_ready |-> mem_ce_n);
    p_no_oe_in_write_r3: assert property (@(posedge clk) disable iff (rst)
        !mem_we_n |-> mem_oe_n);
    p_we_with_ce_r3: assert property (@(posedge clk) disable iff (rst)
        !mem_we_n |-> !mem_ce_n);
    p_we_width_r4: assert property (@(posedge clk) disable iff (rst)
        $rose(mem_we_n) |-> (we_low_q == WP_CYC));
    p_addr_hold_r5: assert property (@(posedge clk) disable iff (rst)
        !mem_ce_n |=> (mem_ce_n || $stable(mem_addr)));
    p_we_after_ce_r5: assert property (@(posedge clk) disable iff (rst)
        $fell(mem_we_n) |-> $past(!mem_ce_n));
    p_drive_in_pulse_r6: assert property (@(posedge clk) disable iff (rst)
        mem_dq_oe |-> !mem_we_n);
    p_rsp_single_r8: assert property (@(posedge clk) disable iff (rst)
        rsp_valid |=> !rsp_valid);
    p_busy_on_rsp_r8: assert property (@(posedge clk) disable iff (rst)
        rsp_valid |-> !req_ready);
    p_turnaround_r9: assert property (@(posedge clk) disable iff (rst)
        $rose(mem_dq_oe) |-> (oe_gap_q >= HZ_CYC));
endmodule

bind sramc_ctrl sramc_ctrl_chk #(
    .ADDR_W (ADDR_W),
    .HZ_CYC (HZ_CYC),
    .WP_CYC (WP_CYC)
) u_chk (
    .clk       (clk),
    .rst       (rst),
    .req_ready (req_ready),
    .rsp_valid (rsp_valid),
    .mem_addr  (mem_addr),
    .mem_ce_n  (mem_ce_n),
    .mem_we_n  (mem_we_n),
    .mem_oe_n  (mem_oe_n),
    .mem_dq_oe (mem_dq_oe)
);

// File: tb/sramc_ctrl_test.sv
module sramc_ctrl_test;
    // Expected cycle counts at a 4 ns clock, from the requirements.
    localparam int RD_EXP = 3;   // ceil(10/4)
    localparam int WP_EXP = 2;   // max(ceil(8/4), ceil(7/4), ceil(10/4)-1)
    localparam int WC_EXP = 3;   // ceil(10/4)
    localparam int HZ_EXP = 5;   // ceil(20/4), float time raised for this bench

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        req_valid = 1'b0;
    logic        req_ready;
    logic        req_write = 1'b0;
    logic [14:0] req_addr = '0;
    logic [7:0]  req_wdata = '0;
    logic [7:0]  rsp_rdata;
    logic        rsp_valid;
    logic [14:0] mem_addr;
    logic        mem_ce_n, mem_we_n, mem_oe_n, mem_dq_oe;
    logic [7:0]  mem_dq_out;
    logic [7:0]  mem_dq_in = 8'hA5;

    always #2 clk = ~clk;

    sramc_ctrl #(.T_HZOE_NS(20)) uut (
        .clk(clk), .rst(rst),
        .req_valid(req_valid), .req_ready(req_ready), .req_write(req_write),
        .req_addr(req_addr), .req_wdata(req_wdata),
        .rsp_rdata(rsp_rdata), .rsp_valid(rsp_valid),
        .mem_addr(mem_addr), .mem_ce_n(mem_ce_n), .mem_we_n(mem_we_n),
        .mem_oe_n(mem_oe_n), .mem_dq_out(mem_dq_out), .mem_dq_oe(mem_dq_oe),
        .mem_dq_in(mem_dq_in)
    );

    int n_checks = 0;
    int n_fail   = 0;
    bit mon_on   = 1'b0;

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual=%0h expected=%0h at %0t", req, act, exp, $time);
        end
    endtask

    logic [7:0] ref_mem [int];
    logic [7:0] ram     [int];
    logic [7:0] exp_q   [$];

    // Memory model and strobe monitors, all sampled at the falling edge.
    int          rc_cnt = 0, we_cnt = 0, oe_cnt = 0, ce_cnt = 0, gap = 1000;
    bit          ce_had_we = 0, prev_ce_n = 1, prev_we_n = 1, prev_oe_n = 1;
    bit          prev_drv = 0, prev_rsp = 0;
    logic [14:0] prev_addr = '0;
    logic [7:0]  we_data = '0;

    always @(negedge clk) begin
        if (mon_on) begin
            // R2: idle means standby
            if (req_ready) check(mem_ce_n == 1'b1, "R2 ce_n in idle", mem_ce_n, 1);
            // R3: strobe combination during writes
            if (!mem_we_n) begin
                check(mem_oe_n == 1'b1, "R3 oe_n during write", mem_oe_n, 1);
                check(mem_ce_n == 1'b0, "R3 ce_n during write", mem_ce_n, 0);
                // R6: driver on and carrying data during the pulse
                check(mem_dq_oe == 1'b1, "R6 driver during write", mem_dq_oe, 1);
                if (prev_we_n) we_data = mem_dq_out;
                check(mem_dq_out == we_data, "R6 write data stable", mem_dq_out, we_data);
                ram[int'(mem_addr)] = mem_dq_out;
            end else begin
                check(mem_dq_oe == 1'b0, "R6 driver outside write", mem_dq_oe, 0);
            end
            // R5: address stable under select; write strobe after select
            if (!mem_ce_n && !prev_ce_n)
                check(mem_addr == prev_addr, "R5 address stable", mem_addr, prev_addr);
            if (!mem_we_n && prev_we_n)
                check(prev_ce_n == 1'b0, "R5 ce before we", prev_ce_n, 0);
            // R4: write pulse width
            if (mem_we_n && !prev_we_n)
                check(we_cnt == WP_EXP, "R4 we_n low cycles", we_cnt, WP_EXP);
            we_cnt = mem_we_n ? 0 : we_cnt + 1;
            // R7: read window width
            if (mem_oe_n && !prev_oe_n)
                check(oe_cnt == RD_EXP, "R7 oe_n low cycles", oe_cnt, RD_EXP);
            oe_cnt = mem_oe_n ? 0 : oe_cnt + 1;
            // R10: select width of each write
            if (mem_ce_n && !prev_ce_n && ce_had_we)
                check(ce_cnt >= WC_EXP, "R10 ce_n low cycles for write", ce_cnt, WC_EXP);
            if (mem_ce_n) begin ce_cnt = 0; ce_had_we = 0; end
            else begin ce_cnt++; if (!mem_we_n) ce_had_we = 1; end
            // R9: turnaround after output strobe rises
            if (mem_dq_oe && !prev_drv)
                check(gap >= HZ_EXP, "R9 turnaround cycles", gap, HZ_EXP);
            gap = !mem_oe_n ? 0 : gap + 1;
            // R8: response pulse and ready
            if (rsp_valid) begin
                check(!prev_rsp, "R8 single-cycle valid", prev_rsp, 0);
                check(!req_ready, "R8 ready low with response", req_ready, 0);
                if (exp_q.size() == 0) begin
                    check(1'b0, "R8 unexpected response", rsp_rdata, 0);
                end else begin
                    check(rsp_rdata == exp_q[0], "R7 read data", rsp_rdata, exp_q[0]);
                    void'(exp_q.pop_front());
                end
            end
        end
        // Read model: data valid only after the full access time.
        rc_cnt = (!mem_ce_n && !mem_oe_n && mem_we_n) ? rc_cnt + 1 : 0;
        if (rc_cnt >= RD_EXP && ram.exists(int'(mem_addr))) mem_dq_in = ram[int'(mem_addr)];
        else mem_dq_in = 8'hA5;
        prev_ce_n = mem_ce_n; prev_we_n = mem_we_n; prev_oe_n = mem_oe_n;
        prev_drv  = mem_dq_oe; prev_rsp = rsp_valid; prev_addr = mem_addr;
    end

    task automatic host_req(input bit wr, input logic [14:0] a, input logic [7:0] d);
        @(negedge clk);
        req_valid = 1'b1; req_write = wr; req_addr = a; req_wdata = d;
        while (!req_ready) @(negedge clk);
        if (wr) ref_mem[int'(a)] = d;
        else exp_q.push_back(ref_mem[int'(a)]);
        @(negedge clk);
        req_valid = 1'b0;
    endtask

    task automatic summary;
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        // R1: values during reset
        check(mem_ce_n && mem_we_n && mem_oe_n, "R1 strobes in reset",
              {mem_ce_n, mem_we_n, mem_oe_n}, 3'b111);
        check(!mem_dq_oe && !rsp_valid, "R1 driver/valid in reset", {mem_dq_oe, rsp_valid}, 0);
        rst = 1'b0;
        @(negedge clk);
        check(mem_ce_n && mem_we_n && mem_oe_n && !mem_dq_oe && req_ready && !rsp_valid,
              "R1 state after reset",
              {mem_ce_n, mem_we_n, mem_oe_n, mem_dq_oe, req_ready, rsp_valid}, 6'b111010);
        mon_on = 1'b1;

        host_req(1, 15'h0000, 8'h3C);
        host_req(1, 15'h7FFF, 8'hC3);
        host_req(1, 15'h1234, 8'hFF);
        host_req(1, 15'h4ACE, 8'h00);
        host_req(0, 15'h0000, 8'h00);
        host_req(0, 15'h7FFF, 8'h00);
        // read immediately followed by write: turnaround path (R9)
        host_req(0, 15'h1234, 8'h00);
        host_req(1, 15'h1234, 8'h5A);
        host_req(0, 15'h1234, 8'h00);
        host_req(0, 15'h4ACE, 8'h00);
        host_req(1, 15'h0001, 8'h81);
        host_req(0, 15'h0001, 8'h00);
        host_req(0, 15'h0001, 8'h00);
        // idle stretch: strobes must stay in standby (R2)
        repeat (10) @(negedge clk);
        for (int i = 0; i < 16; i++) host_req(1, 15'(i * 2049), 8'(i * 17 + 1));
        for (int i = 15; i >= 0; i--) host_req(0, 15'(i * 2049), 8'h00);
        repeat (12) @(negedge clk);
        check(exp_q.size() == 0, "R8 all reads answered", exp_q.size(), 0);
        summary();
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        n_checks++; n_fail++;
        $display("FAIL watchdog R8: actual=timeout expected=completion");
        summary();
        $finish;
    end
endmodule